// File: doc/BRIEF.md
# Accumulator ALU with Nibble Flags

This block is the arithmetic and logic unit of a small accumulator machine. Each operation takes the accumulator value, a second operand, the current flag byte and a 4-bit operation code. It produces an 8-bit result, a new flag byte, and a write strobe that tells the register file whether the accumulator takes the result. The flag byte holds four condition bits in its upper nibble: zero, subtract, half-carry and carry.

Operations enter and leave as a valid/ready stream. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. With the output register enabled (`REG_OUT=1`), the answer appears one cycle later and stays on the outputs with `out_valid` high until a cycle where `out_ready` is high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle, so a full slot can be emptied and refilled on one edge. With `REG_OUT=0` the stage is a wire: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the result is combinational.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. The lower four bits of `flags_out` are always 0, and the lower four bits of `flags_in` have no effect.
- R2: Codes 0x0 (add) and 0x1 (add with carry) form acc+opnd, plus the incoming C for 0x1. They set C on a carry out of bit 7 and H on a carry out of bit 3, with the carry-in counted in both, so a total of 0x100 gives C=1. They clear N, set Z when the 8-bit result is 0, and write the accumulator.
- R3: Codes 0x2 (subtract), 0x3 (subtract with borrow, which also subtracts the incoming C) and 0x4 (compare) set N. They set C when the subtrahend, including the borrow-in, exceeds acc, set H when the same holds for the low nibbles, and set Z when the 8-bit difference is 0. Compare drives `acc_we`=0 and returns acc unchanged as the result.
- R4: Code 0x5 (AND) sets H and clears N and C. Codes 0x6 (OR) and 0x7 (XOR) clear N, H and C. All three set Z on a zero result and write the accumulator.
- R5: Code 0x8 (increment) and code 0x9 (decrement) act on acc alone and keep C. Increment clears N and sets H when the low nibble of the result is 0x0. Decrement sets N and sets H when that nibble is 0xF. Both set Z on a zero result and wrap modulo 256.
- R6: Code 0xA (complement) returns ~acc, writes the accumulator, sets N and H, and keeps Z and C.
- R7: Code 0xB (set carry) and code 0xC (complement carry) clear N and H, keep Z, and set C or invert it respectively. Both drive `acc_we`=0 and return acc as the result.
- R8: Codes 0xD to 0xF change nothing. The result is acc, `acc_we` is 0, and the flag byte is `flags_in` with its low nibble cleared.
- R9: While `out_valid` is high and `out_ready` is low, `result`, `flags_out` and `acc_we` hold steady and `in_ready` is low. After reset `out_valid` is 0 and `in_ready` is 1.
- R10: With `REG_OUT=1`, an operation accepted on one edge is presented with `out_valid` high after that edge. Each accepted operation gives exactly one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can accept an operation this cycle |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 8 | Operation result |
| flags_out | output | 8 | New flag byte |
| acc_we | output | 1 | Accumulator should load `result` |

## Verification
The bench builds the block with its default `REG_OUT=1`, so every operation passes through the output register. This exposes holding under back-pressure and the same-edge drain and refill. The data width keeps its default of 8, so the carry and half-carry edges (0x0F+0x01, 0xFF plus carry-in, 0x00 minus one) are reached directly. The bench also drives junk into the low nibble of the incoming flags and all three unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NIB = 4;
  localparam int OPW = 4;
  localparam int FZ  = 7;
  localparam int FN  = 6;
  localparam int FH  = 5;
  localparam int FC  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'h0, OP_ADC = 4'h1, OP_SUB = 4'h2, OP_SBC = 4'h3,
    OP_CMP = 4'h4, OP_AND = 4'h5, OP_OR  = 4'h6, OP_XOR = 4'h7,
    OP_INC = 4'h8, OP_DEC = 4'h9, OP_CPL = 4'hA, OP_SCF = 4'hB,
    OP_CCF = 4'hC
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          z;
    logic          n;
    logic          h;
    logic          c;
    logic          we;
  } unit_out_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = DW,
  parameter int H = NIB
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output unit_out_t      o
);
  logic [W:0]   wide;
  logic [H:0]   low;
  logic         ci;
  logic [W-1:0] step;

  always_comb begin
    o    = '0;
    wide = '0;
    low  = '0;
    step = '0;
    ci   = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        ci   = (op == OP_ADC) && cin;
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        low  = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, ci};
        o.res = wide[W-1:0];
        o.c   = wide[W];
        o.h   = low[H];
        o.n   = 1'b0;
        o.we  = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ci   = (op == OP_SBC) && cin;
        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
        low  = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, ci};
        o.res = (op == OP_CMP) ? a : wide[W-1:0];
        o.c   = wide[W];
        o.h   = low[H];
        o.n   = 1'b1;
        o.we  = (op != OP_CMP);
      end
      OP_INC: begin
        step  = a + {{(W-1){1'b0}}, 1'b1};
        o.res = step;
        o.h   = (step[H-1:0] == '0);
        o.n   = 1'b0;
        o.c   = cin;
        o.we  = 1'b1;
      end
      OP_DEC: begin
        step  = a - {{(W-1){1'b0}}, 1'b1};
        o.res = step;
        o.h   = (step[H-1:0] == {H{1'b1}});
        o.n   = 1'b1;
        o.c   = cin;
        o.we  = 1'b1;
      end
      default: o = '0;
    endcase
    if (op == OP_CMP) o.z = (wide[W-1:0] == '0);
    else if (op == OP_INC || op == OP_DEC) o.z = (step == '0);
    else o.z = (wide[W-1:0] == '0);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           zin,
  input  logic           cin,
  output unit_out_t      o
);
  logic [W-1:0] v;

  always_comb begin
    o = '0;
    v = a;
    unique case (op)
      OP_AND: begin v = a & b; o.h = 1'b1; o.we = 1'b1; end
      OP_OR:  begin v = a | b; o.we = 1'b1; end
      OP_XOR: begin v = a ^ b; o.we = 1'b1; end
      OP_CPL: begin v = ~a; o.n = 1'b1; o.h = 1'b1; o.c = cin; o.we = 1'b1; end
      OP_SCF: begin o.c = 1'b1; end
      OP_CCF: begin o.c = ~cin; end
      default: v = a;
    endcase
    o.res = v;
    if (op == OP_CPL || op == OP_SCF || op == OP_CCF) o.z = zin;
    else o.z = (v == '0);
  end
endmodule

// File: rtl/alu8_outstage.sv
module alu8_outstage
  import alu8_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int PW      = 2 * DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          full;
      logic [PW-1:0] hold;
      assign in_ready  = !full || out_ready;
      assign out_valid = full;
      assign out_data  = hold;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full <= 1'b0;
          hold <= '0;
        end else if (in_ready) begin
          full <= in_valid;
          if (in_valid) hold <= in_data;
        end
      end

      p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
      p_accept_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
      p_drain_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  flags_in,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  result,
  output logic [DW-1:0]  flags_out,
  output logic           acc_we
);
  localparam int PW = 2 * DW + 1;

  unit_out_t     ar_o, lg_o, pick;
  logic [DW-1:0] nx_flg;
  logic [PW-1:0] nx_pack, out_pack;

  alu8_arith #(.W(DW), .H(NIB)) u_arith (
    .op(op), .a(acc), .b(opnd), .cin(flags_in[FC]), .o(ar_o)
  );

  alu8_logic #(.W(DW)) u_logic (
    .op(op), .a(acc), .b(opnd), .zin(flags_in[FZ]), .cin(flags_in[FC]), .o(lg_o)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC: pick = ar_o;
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_SCF, OP_CCF:          pick = lg_o;
      default: begin
        pick.res = acc;
        pick.z   = flags_in[FZ];
        pick.n   = flags_in[FN];
        pick.h   = flags_in[FH];
        pick.c   = flags_in[FC];
        pick.we  = 1'b0;
      end
    endcase
    nx_flg         = '0;
    nx_flg[FZ]     = pick.z;
    nx_flg[FN]     = pick.n;
    nx_flg[FH]     = pick.h;
    nx_flg[FC]     = pick.c;
    nx_pack        = {pick.we, nx_flg, pick.res};
  end

  alu8_outstage #(.REG_OUT(REG_OUT), .PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(nx_pack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_pack)
  );

  assign result    = out_pack[DW-1:0];
  assign flags_out = out_pack[2*DW-1:DW];
  assign acc_we    = out_pack[PW-1];

  p_low_nibble_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[NIB-1:0] == '0));
  p_cmp_keeps_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |-> (!nx_pack[PW-1] && nx_pack[DW-1:0] == acc));
  p_incdec_keep_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_INC || op == OP_DEC)) |-> (nx_pack[DW+FC] == flags_in[FC]));
  p_cpl_keep_zc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CPL) |->
      (nx_pack[DW+FZ] == flags_in[FZ] && nx_pack[DW+FC] == flags_in[FC]));
  p_unused_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_CCF) |-> (!nx_pack[PW-1] && nx_pack[DW-1:0] == acc));
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = 4'h0;
  logic [7:0] acc = 8'h00, opnd = 8'h00, flags_in = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] result, flags_out;
  logic       acc_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_flags #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .acc(acc), .opnd(opnd), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .flags_out(flags_out), .acc_we(acc_we)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // returns {we, flags, result}
  function automatic logic [16:0] model(input int o, input int a, input int b, input int f);
    int r, cy;
    bit z, n, h, c, we, keepz;
    r = a; we = 1; keepz = 0;
    z = f[7]; n = f[6]; h = f[5]; c = f[4];
    case (o)
      0, 1: begin
        cy = (o == 1) ? int'(f[4]) : 0;
        r = a + b + cy; h = ((a % 16) + (b % 16) + cy) > 15; c = r > 255; n = 0;
      end
      2, 3, 4: begin
        cy = (o == 3) ? int'(f[4]) : 0;
        r = a - b - cy; h = (a % 16) < (b % 16) + cy; c = a < b + cy; n = 1;
      end
      5: begin r = a & b; n = 0; h = 1; c = 0; end
      6: begin r = a | b; n = 0; h = 0; c = 0; end
      7: begin r = a ^ b; n = 0; h = 0; c = 0; end
      8: begin r = (a + 1) & 255; n = 0; h = (r % 16) == 0; end
      9: begin r = (a + 255) & 255; n = 1; h = (r % 16) == 15; end
      10: begin r = 255 - a; n = 1; h = 1; keepz = 1; end
      11: begin we = 0; n = 0; h = 0; c = 1; keepz = 1; end
      12: begin we = 0; n = 0; h = 0; c = !f[4]; keepz = 1; end
      default: begin we = 0; keepz = 1; end
    endcase
    r = r & 255;
    if (!keepz) z = (r == 0);
    if (o == 4) begin we = 0; r = a; end
    model = {we, z, n, h, c, 4'b0000, r[7:0]};
  endfunction

  task automatic run_op(input string tag, input int o, input int a, input int b, input int f);
    logic [16:0] e;
    e = model(o, a, b, f);
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; flags_in = f[7:0];
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " result"}, int'(result), int'(e[7:0]));
    chk({tag, " flags"}, int'(flags_out), int'(e[15:8]));
    chk({tag, " we"}, int'(acc_we), int'(e[16]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_add;
    run_op("R2 add wrap", 0, 8'h3A, 8'hC6, 8'h00);
    chk("R2 add wrap literal flags", int'(flags_out), 8'hB0);
    run_op("R2 add half", 0, 8'h0F, 8'h01, 8'h00);
    chk("R2 add half literal", int'(flags_out), 8'h20);
    run_op("R2 adc carry-in to 0x100", 1, 8'hFF, 8'h00, 8'h10);
    chk("R2 adc 0x100 literal", int'(flags_out), 8'hB0);
    run_op("R2 add ignores carry-in", 0, 8'h10, 8'h20, 8'h10);
    run_op("R2 adc no carry-in", 1, 8'h7F, 8'h01, 8'h00);
  endtask

  task automatic t_sub;
    run_op("R3 sub half borrow", 2, 8'h10, 8'h01, 8'h00);
    chk("R3 sub half literal", int'(flags_out), 8'h60);
    run_op("R3 sub full borrow", 2, 8'h01, 8'h02, 8'h00);
    chk("R3 sub borrow literal", int'(flags_out), 8'h70);
    run_op("R3 sbc borrow-in", 3, 8'h05, 8'h05, 8'h10);
    run_op("R3 sbc to zero", 3, 8'h06, 8'h05, 8'h10);
    run_op("R3 cmp equal", 4, 8'h42, 8'h42, 8'h00);
    chk("R3 cmp literal we", int'(acc_we), 0);
    chk("R3 cmp literal flags", int'(flags_out), 8'hC0);
    run_op("R3 cmp less", 4, 8'h20, 8'h31, 8'h00);
  endtask

  task automatic t_logic;
    run_op("R4 and zero", 5, 8'hF0, 8'h0F, 8'h10);
    chk("R4 and literal", int'(flags_out), 8'hA0);
    run_op("R4 and nonzero", 5, 8'hFC, 8'h3F, 8'h70);
    run_op("R4 or zero", 6, 8'h00, 8'h00, 8'h70);
    run_op("R4 xor ones", 7, 8'h55, 8'hAA, 8'hF0);
    run_op("R4 xor self", 7, 8'h5A, 8'h5A, 8'h00);
  endtask

  task automatic t_incdec;
    run_op("R5 inc wrap keep c", 8, 8'hFF, 8'h12, 8'h10);
    chk("R5 inc wrap literal", int'(flags_out), 8'hB0);
    run_op("R5 inc plain", 8, 8'h0E, 8'h00, 8'h40);
    run_op("R5 dec to zero", 9, 8'h01, 8'h00, 8'h00);
    chk("R5 dec zero literal", int'(flags_out), 8'hC0);
    run_op("R5 dec wrap", 9, 8'h00, 8'h00, 8'h10);
    chk("R5 dec wrap literal", int'(flags_out), 8'h70);
  endtask

  task automatic t_cpl;
    run_op("R6 cpl keeps zc", 10, 8'h35, 8'h00, 8'h90);
    chk("R6 cpl literal", int'(result), 8'hCA);
    run_op("R6 cpl clear zc", 10, 8'hFF, 8'h00, 8'h00);
  endtask

  task automatic t_carry;
    run_op("R7 scf", 11, 8'h12, 8'h00, 8'hE0);
    chk("R7 scf literal", int'(flags_out), 8'h90);
    run_op("R7 ccf clear", 12, 8'h12, 8'h00, 8'h70);
    run_op("R7 ccf set", 12, 8'h12, 8'h00, 8'h80);
  endtask

  task automatic t_unused;
    run_op("R8 code D", 13, 8'h77, 8'h11, 8'hFF);
    chk("R1 low nibble ignored", int'(flags_out), 8'hF0);
    run_op("R8 code E", 14, 8'h00, 8'hFF, 8'h50);
    run_op("R8 code F", 15, 8'h9C, 8'h01, 8'h0F);
    run_op("R1 add low nibble junk", 0, 8'h01, 8'h01, 8'h0F);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    op = 4'h0; acc = 8'h11; opnd = 8'h22; flags_in = 8'h00; in_valid = 1'b1;
    @(posedge clk);
    #1 op = 4'h7; acc = 8'hF0; opnd = 8'h0F;
    @(negedge clk);
    chk("R10 first shown", int'(out_valid), 1);
    chk("R9 stall in_ready", int'(in_ready), 0);
    chk("R9 stall result", int'(result), 8'h33);
    @(negedge clk);
    chk("R9 still held", int'(result), 8'h33);
    chk("R9 still valid", int'(out_valid), 1);
    out_ready = 1'b1;
    #1 chk("R9 ready when draining", int'(in_ready), 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R10 refill same edge", int'(result), 8'hFF);
    chk("R10 refill valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R10 one output only", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_cpl();
    t_carry();
    t_unused();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    int n;
    for (n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule